// File: doc/BRIEF.md
# Single-Cycle Execute and Writeback Datapath

This block is the execute and writeback half of a 32-bit processor that completes one instruction per clock. It receives an instruction word together with already-decoded control signals. From these it reads two source registers, optionally extends a 16-bit immediate, runs one ALU operation, optionally reads or writes a word of data memory, and writes a result back into the register file on the clock edge that ends the cycle. It also reports whether the two source registers hold equal values, so that a fetch unit outside the block can resolve a branch.

Instruction fetch, program-counter update and opcode decoding sit outside this block. The control inputs can select between zero and sign extension and between two destination fields. With these choices one datapath serves register-register arithmetic, OR with an immediate, word loads and word stores.

Top module: `sc_exec_path`

## Requirements
- R1: Source register A is selected by instruction bits 25:21 and source register B by bits 20:16. The two read values are combinational in the same cycle.
- R2: A register write happens only at a rising clock edge with `reg_wr`=1. The destination is instruction bits 15:11 when `reg_dst`=1 and bits 20:16 when `reg_dst`=0. With `reg_wr`=0 no register changes.
- R3: Register 0 always reads as zero, and a write aimed at it is discarded.
- R4: The immediate is instruction bits 15:0. With `ext_sign`=0 the upper 16 bits are zero. With `ext_sign`=1 the upper 16 bits copy bit 15.
- R5: The second ALU operand is register B when `alu_src`=0 and the extended immediate when `alu_src`=1.
- R6: `alu_op` encodes the ALU operation: 2'b00 adds, 2'b01 subtracts (A minus operand), and 2'b10 or 2'b11 gives bitwise OR. The result appears on `alu_out` in the same cycle, wrapping modulo 2^32.
- R7: Data memory holds 256 words indexed by `alu_out` bits 9:2. Its read is combinational. With `mem_wr`=1 it stores register B at the rising edge. With `mem_wr`=0 its contents do not change.
- R8: `wb_data` is `alu_out` when `mem_to_reg`=0 and the addressed memory word when `mem_to_reg`=1.
- R9: `equal` is 1 exactly when register A equals register B, as selected by R1.
- R10: A synchronous active-low reset clears every register to zero. Data memory is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register and memory writes happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| instr | input | 32 | Instruction word supplying register fields and immediate |
| reg_dst | input | 1 | Destination field select: 1 = bits 15:11, 0 = bits 20:16 |
| reg_wr | input | 1 | Register write enable |
| ext_sign | input | 1 | Immediate extension: 1 = sign, 0 = zero |
| alu_src | input | 1 | Second operand select: 1 = immediate, 0 = register B |
| alu_op | input | 2 | ALU operation code |
| mem_wr | input | 1 | Data memory write enable |
| mem_to_reg | input | 1 | Writeback select: 1 = memory word, 0 = ALU result |
| alu_out | output | 32 | ALU result, also the memory byte address |
| wb_data | output | 32 | Value presented for register writeback |
| equal | output | 1 | Register A equals register B |

## Verification
The assertions assume that the control inputs are defined and held steady around each rising edge. They also assume that a load reads only words that a store has already written, because the memory has no reset and unwritten words are undefined. The stimulus keeps within these limits in two ways. It first writes every memory word with directed stores, and only then lets seeded random stimulus choose register fields, immediates, operations and enables. All inputs change on the falling edge, so they are stable at each rising edge.

// File: rtl/sc_exec_path.sv
module sc_exec_path #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5,
  parameter int MEM_AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic            reg_dst,
  input  logic            reg_wr,
  input  logic            ext_sign,
  input  logic            alu_src,
  input  logic [1:0]      alu_op,
  input  logic            mem_wr,
  input  logic            mem_to_reg,
  output logic [XLEN-1:0] alu_out,
  output logic [XLEN-1:0] wb_data,
  output logic            equal
);
  localparam int NREGS  = 1 << REG_AW;
  localparam int NWORDS = 1 << MEM_AW;
  localparam int IMMW   = 16;

  logic [REG_AW-1:0] src_a, src_b, dst_d, wdest;
  logic [IMMW-1:0]   imm;
  logic [XLEN-1:0]   rf [NREGS];
  logic [XLEN-1:0]   dmem [NWORDS];
  logic [XLEN-1:0]   bus_a, bus_b, imm_x, opnd_b, mem_rd;
  logic [MEM_AW-1:0] maddr;
  logic              unused_opfield;

  assign src_a = instr[25:21];
  assign src_b = instr[20:16];
  assign dst_d = instr[15:11];
  assign imm   = instr[15:0];
  assign unused_opfield = ^instr[31:26];

  assign wdest = reg_dst ? dst_d : src_b;
  assign bus_a = (src_a == '0) ? '0 : rf[src_a];
  assign bus_b = (src_b == '0) ? '0 : rf[src_b];
  assign equal = (bus_a == bus_b);

  assign imm_x  = ext_sign ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
                           : {{(XLEN-IMMW){1'b0}}, imm};
  assign opnd_b = alu_src ? imm_x : bus_b;

  always_comb begin
    unique case (alu_op)
      2'b00:   alu_out = bus_a + opnd_b;
      2'b01:   alu_out = bus_a - opnd_b;
      default: alu_out = bus_a | opnd_b;
    endcase
  end

  assign maddr   = alu_out[MEM_AW+1:2];
  assign mem_rd  = dmem[maddr];
  assign wb_data = mem_to_reg ? mem_rd : alu_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (reg_wr && wdest != '0) begin
      rf[wdest] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_wr) dmem[maddr] <= bus_b;
  end

  // register 0 storage never changes (R3)
  p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wdest == '0) |=> (rf[0] == '0));

  // a write lands at the chosen destination on the next edge (R2)
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wdest != '0) |=> (rf[$past(wdest)] == $past(wb_data)));

  // with no write enable the register read as A keeps its value (R2)
  p_hold_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> (rf[$past(src_a)] == $past(rf[src_a])));

  // a store places register B at the ALU word address (R7)
  p_store_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (dmem[$past(maddr)] == $past(bus_b)));

  // subtracting equal registers yields zero (R6, R9)
  p_sub_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 2'b01 && !alu_src && equal) |-> (alu_out == '0));

  // reset leaves register A reading zero (R10)
  p_reset_clear_r10: assert property (@(posedge clk)
    (!rst_n) |=> (bus_a == '0));
endmodule

// File: tb/sc_exec_path_test.sv
module sc_exec_path_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        reg_dst, reg_wr, ext_sign, alu_src, mem_wr, mem_to_reg;
  logic [1:0]  alu_op;
  logic [31:0] alu_out, wb_data;
  logic        equal;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] m_rf  [32];
  logic [31:0] m_mem [256];

  always #5 clk = ~clk;

  sc_exec_path uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .reg_dst(reg_dst),
    .reg_wr(reg_wr), .ext_sign(ext_sign), .alu_src(alu_src),
    .alu_op(alu_op), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
    .alu_out(alu_out), .wb_data(wb_data), .equal(equal)
  );

  function automatic logic [31:0] f_ext(input logic [15:0] v, input logic sx);
    return sx ? {{16{v[15]}}, v} : {16'h0, v};
  endfunction

  function automatic logic [31:0] f_alu(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] op);
    if (op == 2'b00) return a + b;
    if (op == 2'b01) return a - b;
    return a | b;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [15:0] im);
    return {6'h23, rs, rt, im};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] ins, input logic rdsel, input logic rw,
                     input logic sx, input logic asrc, input logic [1:0] op,
                     input logic mw, input logic m2r, input string tag);
    logic [31:0] a, b, o, res, wb;
    logic [4:0]  dst;
    instr = ins; reg_dst = rdsel; reg_wr = rw; ext_sign = sx;
    alu_src = asrc; alu_op = op; mem_wr = mw; mem_to_reg = m2r;
    #2;
    a   = m_rf[ins[25:21]];
    b   = m_rf[ins[20:16]];
    o   = asrc ? f_ext(ins[15:0], sx) : b;
    res = f_alu(a, o, op);
    wb  = m2r ? m_mem[res[9:2]] : res;
    dst = rdsel ? ins[15:11] : ins[20:16];
    chk(tag, alu_out, res);
    chk("R9", {31'h0, equal}, {31'h0, a == b});
    chk("R8", wb_data, wb);
    @(posedge clk);
    if (rw && dst != 5'd0) m_rf[dst] = wb;
    if (mw) m_mem[res[9:2]] = b;
    @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < 32; r++)
      cyc(mk(5'(r), 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    for (int i = 0; i < 256; i++) m_mem[i] = 32'h0;
    rst_n = 1'b0; instr = 32'h0; reg_dst = 0; reg_wr = 0; ext_sign = 0;
    alu_src = 0; alu_op = 2'b00; mem_wr = 0; mem_to_reg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    read_all("R10");

    // fill registers with OR-immediate using zero extension, dest = rt (R2, R4, R6)
    for (int r = 1; r < 32; r++)
      cyc(mk(5'd0, 5'(r), 16'($urandom) | 16'h8000), 1'b0, 1'b1, 1'b0, 1'b1,
          2'b10, 1'b0, 1'b0, "R4");

    // write to register 0 via rd, then read it back (R3)
    cyc({6'h0, 5'd3, 5'd4, 5'd0, 11'h0}, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R3");
    cyc(mk(5'd0, 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R3");

    // sign extension of a negative immediate (R4, R5)
    cyc(mk(5'd0, 5'd7, 16'h8001), 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, "R4");
    chk("R4", f_ext(16'h8001, 1'b1), 32'hFFFF8001);

    // R-type add into rd, then disabled write leaves it (R2, R1)
    cyc({6'h0, 5'd5, 5'd6, 5'd20, 11'h0}, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R1");
    cyc({6'h0, 5'd8, 5'd9, 5'd20, 11'h0}, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, "R2");
    cyc(mk(5'd20, 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R2");

    // same register on both ports: equal and subtract to zero (R9, R6)
    cyc(mk(5'd11, 5'd11, 16'h0), 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, "R6");

    // fill all memory words with stores from base register 0 (R7)
    for (int k = 0; k < 256; k++)
      cyc(mk(5'd0, 5'(k % 31 + 1), 16'(k * 4)), 1'b0, 1'b0, 1'b1, 1'b1,
          2'b00, 1'b1, 1'b0, "R7");

    // loads into rt, then read back (R7, R8)
    cyc(mk(5'd0, 5'd9, 16'd20), 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, "R7");
    cyc(mk(5'd9, 5'd0, 16'h0), 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, "R8");

    // random mix of operations and enables (R1, R5, R6, R7, R8)
    for (int n = 0; n < 3000; n++) begin
      automatic logic [31:0] ins = $urandom;
      automatic logic [31:0] ctl = $urandom;
      cyc(ins, ctl[0], ctl[1], ctl[2], ctl[3], ctl[5:4], ctl[6] & ctl[7], ctl[8], "R6");
    end

    read_all("R2");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule